// File: doc/BRIEF.md
# Predicated Logic, Shift and Swap Unit

This execution unit serves a 24-bit processor datapath. Each cycle it takes one operation and returns one registered result, a write-enable for the destination register and an updated set of condition flags. The operations are bitwise AND, OR, XOR and NOT, three shifts (logical right, arithmetic right, logical left) and a byte swap of the low half-word. The second operand is either a register value or a 7-bit immediate field. Logic operations sign-extend that field. Shifts read it as an unsigned amount.

Register-form logic operations can be made conditional on the incoming carry flag. When the condition fails, the unit produces a cancelled slot: no write-back and no flag change. Decode, the register file and memory access lie outside the block. The unit executes every cycle, and a caller that has nothing to issue ignores the outputs.

Top module: `lss_unit`

## Requirements
- R1: Opcodes AND=0, OR=1, XOR=2 combine `a_i` with a second operand. That operand is `b_i` when `src_imm_i`=0. When `src_imm_i`=1 it is `imm_i` sign-extended from bit 6 to 24 bits.
- R2: NOT (opcode 3) returns the one's complement of the selected second operand, either the register or the sign-extended immediate. `a_i` plays no part.
- R3: For opcodes 0..3 with `src_imm_i`=0, `pred_i` selects the condition from the carry bit `flags_i[0]`: 0 or 3 always executes, 1 executes only if C=1, and 2 executes only if C=0. A failed condition gives `wr_en_o`=0, `result_o`=0 and `flags_o` equal to `flags_i`.
- R4: `pred_i` has no effect on immediate-form logic operations, on shifts or on swap. These always give `wr_en_o`=1.
- R5: SRL (opcode 4) and SLL (opcode 6) shift `a_i` right or left and fill with zeros. The amount is the full unsigned value of `b_i`, or `imm_i` zero-extended when `src_imm_i`=1.
- R6: SRA (opcode 5) shifts `a_i` right and fills with copies of `a_i[23]`.
- R7: An amount of 24 or more gives all zeros for SRL and SLL. For SRA it gives 24 copies of `a_i[23]`.
- R8: SWAP (opcode 7) returns {8'h00, `b_i[7:0]`, `b_i[15:8]`}. It ignores `src_imm_i` and `imm_i` and passes `flags_i` through unchanged.
- R9: An executed logic operation or shift sets N (`flags_o[3]`) to `result_o[23]` and Z (`flags_o[2]`) to 1 exactly when `result_o` is zero. It clears V (`flags_o[1]`) and copies C (`flags_o[0]`) from `flags_i[0]`.
- R10: Outputs appear one clock after their inputs. While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation code |
| src_imm_i | input | 1 | 1 selects the immediate as second operand |
| a_i | input | 24 | Destination-register operand / shift source |
| b_i | input | 24 | Source-register operand / shift amount / swap source |
| imm_i | input | 7 | Immediate field |
| pred_i | input | 2 | Carry predicate mode |
| flags_i | input | 4 | Current flags {N,Z,V,C} |
| result_o | output | 24 | Registered result |
| wr_en_o | output | 1 | Registered write-enable |
| flags_o | output | 4 | Registered flags {N,Z,V,C} |

## Verification
Predicate evaluation and flag generation can fall in the same cycle. The carry bit that decides whether a register-form logic operation runs is also the bit that must come back out unchanged, while N and Z would be rebuilt from a result that a cancelled slot must drop. The bench provokes the overlap with directed cases where a failed predicate meets operands that would give a zero or negative result. Random cycles then mix all predicate modes and carry values with both operand sources. Each outcome is judged by comparing write-enable, result and all four flags with a bench model. A cancelled slot must show exactly the incoming flags, and an executed one must show the freshly computed N and Z.

// File: rtl/lss_pkg.sv
package lss_pkg;

    typedef enum logic [2:0] {
        OP_AND  = 3'd0,
        OP_OR   = 3'd1,
        OP_XOR  = 3'd2,
        OP_NOT  = 3'd3,
        OP_SRL  = 3'd4,
        OP_SRA  = 3'd5,
        OP_SLL  = 3'd6,
        OP_SWAP = 3'd7
    } lss_op_e;

    typedef enum logic [1:0] {
        PR_ALWAYS = 2'd0,
        PR_IF_C   = 2'd1,
        PR_IF_NC  = 2'd2,
        PR_ALT    = 2'd3
    } lss_pred_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } lss_flags_t;

endpackage

// File: rtl/lss_logic.sv
module lss_logic #(
    parameter int W = 24
) (
    input  lss_pkg::lss_op_e op_i,
    input  logic [W-1:0]     lhs_i,
    input  logic [W-1:0]     rhs_i,
    output logic [W-1:0]     res_o
);
    import lss_pkg::*;

    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = lhs_i & rhs_i;
            OP_OR:   res_o = lhs_i | rhs_i;
            OP_XOR:  res_o = lhs_i ^ rhs_i;
            default: res_o = ~rhs_i;
        endcase
    end

endmodule

// File: rtl/lss_shift.sv
module lss_shift #(
    parameter int W = 24
) (
    input  logic [W-1:0] val_i,
    input  logic [W-1:0] amt_i,
    input  logic         left_i,
    input  logic         arith_i,
    output logic [W-1:0] res_o
);
    localparam int AW = $clog2(W);

    logic         fill;
    logic         over;
    logic [W-1:0] src_rev;
    logic [W-1:0] out_rev;
    logic [W-1:0] stg [AW+1];
    logic [W-1:0] right_res;

    assign fill = arith_i & ~left_i & val_i[W-1];
    assign over = (|amt_i[W-1:AW]) || (int'(amt_i[AW-1:0]) >= W);

    always_comb begin
        for (int i = 0; i < W; i++) begin
            src_rev[i] = val_i[W-1-i];
        end
    end

    assign stg[0] = left_i ? src_rev : val_i;

    genvar k;
    generate
        for (k = 0; k < AW; k++) begin : g_stage
            assign stg[k+1] = amt_i[k]
                ? {{(1 << k){fill}}, stg[k][W-1:(1 << k)]}
                : stg[k];
        end
    endgenerate

    assign right_res = over ? {W{fill}} : stg[AW];

    always_comb begin
        for (int i = 0; i < W; i++) begin
            out_rev[i] = right_res[W-1-i];
        end
    end

    assign res_o = left_i ? out_rev : right_res;

endmodule

// File: rtl/lss_unit.sv
module lss_unit #(
    parameter int W     = 24,
    parameter int IMM_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_i,
    input  logic             src_imm_i,
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [1:0]       pred_i,
    input  logic [3:0]       flags_i,
    output logic [W-1:0]     result_o,
    output logic             wr_en_o,
    output logic [3:0]       flags_o
);
    import lss_pkg::*;

    typedef struct packed {
        logic [W-1:0] res;
        logic         wr;
        lss_flags_t   flg;
    } lss_state_t;

    lss_op_e    op;
    lss_pred_e  pred;
    lss_flags_t flg_in;
    logic [W-1:0] imm_sx;
    logic [W-1:0] imm_zx;
    logic [W-1:0] opnd_b;
    logic [W-1:0] amt;
    logic [W-1:0] logic_res;
    logic [W-1:0] shift_res;
    logic         is_logic;
    logic         cond_ok;
    lss_state_t   st_d;
    lss_state_t   st_q;

    assign op     = lss_op_e'(op_i);
    assign pred   = lss_pred_e'(pred_i);
    assign flg_in = lss_flags_t'(flags_i);
    assign imm_sx = {{(W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
    assign imm_zx = {{(W-IMM_W){1'b0}}, imm_i};
    assign opnd_b = src_imm_i ? imm_sx : b_i;
    assign amt    = src_imm_i ? imm_zx : b_i;
    assign is_logic = (op_i[2] == 1'b0);

    lss_logic #(.W(W)) i_logic (
        .op_i  (op),
        .lhs_i (a_i),
        .rhs_i (opnd_b),
        .res_o (logic_res)
    );

    lss_shift #(.W(W)) i_shift (
        .val_i   (a_i),
        .amt_i   (amt),
        .left_i  (op == OP_SLL),
        .arith_i (op == OP_SRA),
        .res_o   (shift_res)
    );

    always_comb begin
        unique case (pred)
            PR_IF_C:  cond_ok = flg_in.c;
            PR_IF_NC: cond_ok = ~flg_in.c;
            default:  cond_ok = 1'b1;
        endcase
        if (!is_logic || src_imm_i) begin
            cond_ok = 1'b1;
        end
    end

    always_comb begin
        st_d     = '0;
        st_d.flg = flg_in;
        if (op == OP_SWAP) begin
            st_d.res = {{(W-16){1'b0}}, b_i[7:0], b_i[15:8]};
            st_d.wr  = 1'b1;
        end else if (cond_ok) begin
            st_d.res   = is_logic ? logic_res : shift_res;
            st_d.wr    = 1'b1;
            st_d.flg.n = st_d.res[W-1];
            st_d.flg.z = (st_d.res == '0);
            st_d.flg.v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.res;
    assign wr_en_o  = st_q.wr;
    assign flags_o  = st_q.flg;

    logic past_ok_q;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    // R3
    cancel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && !wr_en_o) |-> (result_o == '0 && flags_o == $past(flags_i)));

    // R9
    carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q |-> (flags_o[0] == $past(flags_i[0])));

    // R9
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && wr_en_o && $past(op_i) != 3'd7)
            |-> (flags_o[2] == (result_o == '0) && flags_o[1] == 1'b0));

    // R8
    swap_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(op_i) == 3'd7)
            |-> (result_o[W-1:16] == '0 && wr_en_o && flags_o == $past(flags_i)));

    // R4
    no_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && ($past(op_i[2]) || $past(src_imm_i))) |-> wr_en_o);

endmodule

// File: tb/test_lss_unit.sv
module test_lss_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  op;
    logic        src_imm;
    logic [23:0] a, b;
    logic [6:0]  imm;
    logic [1:0]  pred;
    logic [3:0]  flg;
    logic [23:0] result;
    logic        wr_en;
    logic [3:0]  flags;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    lss_unit i_lss_unit (
        .clk(clk), .rst_n(rst_n), .op_i(op), .src_imm_i(src_imm),
        .a_i(a), .b_i(b), .imm_i(imm), .pred_i(pred), .flags_i(flg),
        .result_o(result), .wr_en_o(wr_en), .flags_o(flags)
    );

    // returns {wr, flags[3:0], result[23:0]}
    function automatic logic [28:0] model(input logic [2:0] o, input logic s,
            input logic [23:0] x, input logic [23:0] y, input logic [6:0] im,
            input logic [1:0] p, input logic [3:0] f);
        logic [23:0] sec, r;
        logic [31:0] n;
        logic        run;
        sec = s ? {{17{im[6]}}, im} : y;
        n   = s ? {25'd0, im} : {8'd0, y};
        run = 1'b1;
        if (o < 3'd4 && !s) begin
            if (p == 2'd1) run = f[0];
            if (p == 2'd2) run = !f[0];
        end
        r = '0;
        case (o)
            3'd0: r = x & sec;
            3'd1: r = x | sec;
            3'd2: r = x ^ sec;
            3'd3: r = ~sec;
            3'd4: r = (n >= 24) ? 24'd0 : (x >> n);
            3'd6: r = (n >= 24) ? 24'd0 : (x << n);
            3'd5: begin
                for (int i = 0; i < 24; i++)
                    r[i] = (i + n < 24) ? x[i + n] : x[23];
            end
            default: r = {8'd0, y[7:0], y[15:8]};
        endcase
        if (o == 3'd7) return {1'b1, f, r};
        if (!run)      return {1'b0, f, 24'd0};
        return {1'b1, r[23], (r == 24'd0), 1'b0, f[0], r};
    endfunction

    task automatic check(input string tag, input logic [28:0] got, input logic [28:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got wr=%0b flg=%h res=%h, expected wr=%0b flg=%h res=%h",
                     tag, got[28], got[27:24], got[23:0], exp[28], exp[27:24], exp[23:0]);
        end
    endtask

    task automatic run1(input string tag, input logic [2:0] o, input logic s,
            input logic [23:0] x, input logic [23:0] y, input logic [6:0] im,
            input logic [1:0] p, input logic [3:0] f);
        logic [28:0] e;
        op = o; src_imm = s; a = x; b = y; imm = im; pred = p; flg = f;
        e = model(o, s, x, y, im, p, f);
        @(posedge clk); #1;
        check(tag, {wr_en, flags, result}, e);
    endtask

    initial begin
        #(5 * 200000);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        if (!done) $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; op = 3'd1; src_imm = 1'b0; a = 24'hFFFFFF; b = 24'h123456;
        imm = 7'h7F; pred = 2'd0; flg = 4'hF;
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset", {wr_en, flags, result}, 29'd0);
        rst_n = 1'b1;

        run1("R1 and reg",        3'd0, 0, 24'hF0F0F0, 24'h3C3C3C, 7'h00, 2'd0, 4'h0);
        run1("R1 or imm sext",    3'd1, 1, 24'h000100, 24'h0,      7'h40, 2'd0, 4'h0);
        run1("R1 xor imm pos",    3'd2, 1, 24'h00003F, 24'h0,      7'h3F, 2'd0, 4'h1);
        run1("R2 not imm",        3'd3, 1, 24'h123456, 24'h0,      7'h05, 2'd0, 4'h0);
        run1("R2 not reg",        3'd3, 0, 24'h0,      24'hFFFFFF, 7'h00, 2'd0, 4'hE);
        run1("R3 ifC false",      3'd0, 0, 24'h000000, 24'h0,      7'h00, 2'd1, 4'hA);
        run1("R3 ifC true",       3'd0, 0, 24'h000000, 24'h0,      7'h00, 2'd1, 4'h1);
        run1("R3 ifNC false",     3'd3, 0, 24'h0,      24'h000000, 7'h00, 2'd2, 4'h5);
        run1("R3 ifNC true",      3'd2, 0, 24'h800000, 24'h1,      7'h00, 2'd2, 4'h4);
        run1("R3 mode3 always",   3'd1, 0, 24'h0,      24'h0,      7'h00, 2'd3, 4'h0);
        run1("R4 imm ignores pr", 3'd0, 1, 24'hFFFFFF, 24'h0,      7'h7F, 2'd1, 4'h0);
        run1("R4 shift ign pr",   3'd4, 0, 24'h800000, 24'd4,      7'h00, 2'd2, 4'h1);
        run1("R5 srl imm",        3'd4, 1, 24'hFFFFFF, 24'h0,      7'd23, 2'd0, 4'h0);
        run1("R5 sll reg",        3'd6, 0, 24'h000001, 24'd23,     7'h00, 2'd0, 4'h0);
        run1("R5 sll zero amt",   3'd6, 1, 24'hABCDEF, 24'h0,      7'd0,  2'd0, 4'h0);
        run1("R6 sra neg",        3'd5, 0, 24'h900000, 24'd4,      7'h00, 2'd0, 4'h0);
        run1("R6 sra pos",        3'd5, 1, 24'h400000, 24'h0,      7'd22, 2'd0, 4'h0);
        run1("R7 srl 24",         3'd4, 1, 24'hFFFFFF, 24'h0,      7'd24, 2'd0, 4'h0);
        run1("R7 sra 127",        3'd5, 1, 24'h800001, 24'h0,      7'd127,2'd0, 4'h1);
        run1("R7 sll big reg",    3'd6, 0, 24'hFFFFFF, 24'h100000, 7'h00, 2'd0, 4'h0);
        run1("R7 sra big reg pos",3'd5, 0, 24'h7FFFFF, 24'h000020, 7'h00, 2'd0, 4'h0);
        run1("R8 swap",           3'd7, 1, 24'h0,      24'hAB1234, 7'h7F, 2'd1, 4'h6);

        for (int i = 0; i < 3000; i++) begin
            logic [2:0]  ro;
            logic [23:0] ra, rb;
            ro = 3'($urandom);
            ra = 24'($urandom);
            rb = ($urandom % 4 == 0) ? 24'($urandom % 32) : 24'($urandom);
            if ($urandom % 8 == 0) ra = 24'd0;
            run1("R1 R2 R3 R5 R6 R7 R8 R9 random", ro, 1'($urandom), ra, rb,
                 7'($urandom), 2'($urandom), 4'($urandom));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule